// File: doc/BRIEF.md
# Dirty-Plane Tracker with Self-Refresh Re-Arm Timer

This block watches front-buffer activity for the display planes that feed one pipe and decides when panel self-refresh has to be left and when it may be armed again. Rendering software reports two kinds of event, each carrying a per-plane bitmask. An invalidate means that rendering into those planes has started. A flush means that the rendering has completed, and a flush carries a tag that says whether a page flip caused it. The block keeps a set of busy planes. It sends a one-cycle exit request to the self-refresh controller whenever an event calls for the screen to be refreshed.

When a flush leaves every plane clean and self-refresh is not running, the block starts a delay timer. The delay is longer in software-only tracking mode than in hardware-tracking mode, and both lengths are parameters given in clock cycles. When the delay runs out, the block waits a bounded time for the controller to report idle. It then sends a one-cycle re-activate pulse. If the controller does not report idle in time, the block gives up on that attempt and sends a one-cycle error pulse instead. Any new invalidate cancels a pending re-arm, and so does disabling the tracker. This ensures that no frame update is lost.

Top module: `plane_dirty_rearm`

## Requirements
- R1: Every event mask is ANDed with `pipe_mask` before use. Bits outside `pipe_mask` change nothing and never cause an exit request.
- R2: An enabled invalidate ORs its masked bits into `busy`, which is visible one cycle later. If any masked bit is set, it raises `exit_req` for exactly one cycle, one cycle after the event.
- R3: An enabled flush clears its masked bits from `busy` one cycle later.
- R4: With `hw_mode`=1, a flush raises `exit_req` only when its masked bits are nonzero and `flush_is_flip`=0. A flip-originated flush clears bits silently.
- R5: With `hw_mode`=0, every flush with nonzero masked bits raises `exit_req`, whatever `flush_is_flip` says.
- R6: A flush starts the re-arm timer when three things hold: it leaves `busy` empty, either `sr_active`=0 or the flush itself raises an exit, and no timer is already pending. The delay is HW_DELAY_CYC cycles when `hw_mode`=1 and SW_DELAY_CYC cycles otherwise. If `ctrl_idle`=1, `rearm_req` pulses for one cycle, delay+1 cycles after the clock edge that took the flush.
- R7: An enabled invalidate with nonzero masked bits, arriving while a re-arm is pending, cancels it, and no `rearm_req` follows. On expiry, the re-arm is also skipped if `busy` is nonzero.
- R8: After the delay, if `ctrl_idle` stays 0 for IDLE_TIMEOUT_CYC cycles, the attempt is dropped and `rearm_err` pulses once instead of `rearm_req`. The pulse comes delay+IDLE_TIMEOUT_CYC cycles after the starting edge.
- R9: While `track_en`=0, all events are ignored, `busy` holds its value, no pulse is produced, and any pending re-arm is cancelled.
- R10: On the first enabled cycle after `track_en` was 0, `busy` is cleared to zero.
- R11: An invalidate and a flush in the same cycle apply the flush first and the invalidate second, so a bit named by both ends up busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_en | input | 1 | Tracking enable |
| hw_mode | input | 1 | 1 = hardware-tracking mode, 0 = software-only mode |
| pipe_mask | input | NUM_PLANES | Planes that belong to the tracked pipe |
| inv_valid | input | 1 | Invalidate event strobe |
| inv_mask | input | NUM_PLANES | Planes named by the invalidate |
| flush_valid | input | 1 | Flush event strobe |
| flush_mask | input | NUM_PLANES | Planes named by the flush |
| flush_is_flip | input | 1 | Flush came from a page flip |
| sr_active | input | 1 | Controller reports self-refresh active |
| ctrl_idle | input | 1 | Controller reports idle, no transition in progress |
| busy | output | NUM_PLANES | Current set of dirty planes |
| exit_req | output | 1 | One-cycle request to leave self-refresh |
| rearm_req | output | 1 | One-cycle request to re-activate self-refresh |
| rearm_err | output | 1 | One-cycle flag: idle wait timed out |

## Verification
A corrupted busy set appears on `busy` one cycle after the event that touched it. It appears again later as a missing or spurious `rearm_req`, because the timer start depends on an empty set. A sequencer that is stuck in, or wrongly leaves, its delay or wait phase shows up as a pulse on `rearm_req` or `rearm_err` at the wrong cycle, or as one that is absent. Each pulse is compared against the exact cycle predicted from the delay and timeout parameters, so an off-by-one counter is caught at the first re-arm. The bench also checks that cancelling events suppress the pulse entirely.

// File: rtl/plane_trk_pkg.sv
package plane_trk_pkg;

  typedef enum logic [1:0] {
    RA_IDLE  = 2'd0,
    RA_DELAY = 2'd1,
    RA_WAIT  = 2'd2
  } rearm_st_e;

endpackage

// File: rtl/plane_evt_filter.sv
module plane_evt_filter #(
  parameter int NUM_PLANES = 8
) (
  input  logic                  track_en,
  input  logic                  hw_mode,
  input  logic [NUM_PLANES-1:0] pipe_mask,
  input  logic                  inv_valid,
  input  logic [NUM_PLANES-1:0] inv_mask,
  input  logic                  flush_valid,
  input  logic [NUM_PLANES-1:0] flush_mask,
  input  logic                  flush_is_flip,
  output logic [NUM_PLANES-1:0] inv_bits,
  output logic [NUM_PLANES-1:0] fl_bits,
  output logic                  inv_hit,
  output logic                  flush_seen,
  output logic                  force_exit
);

  logic fl_hit;
  logic fl_exit;

  always_comb begin
    inv_bits   = (track_en && inv_valid)   ? (inv_mask & pipe_mask)   : '0;
    fl_bits    = (track_en && flush_valid) ? (flush_mask & pipe_mask) : '0;
    inv_hit    = |inv_bits;
    fl_hit     = |fl_bits;
    flush_seen = track_en && flush_valid;
    // hardware mode trusts flips to refresh the panel on their own
    fl_exit    = fl_hit && (!hw_mode || !flush_is_flip);
    force_exit = inv_hit || fl_exit;
  end

  always_comb begin
    AST_MASK_INSIDE_PIPE: assert (((inv_bits | fl_bits) & ~pipe_mask) == '0); // R1
  end

endmodule

// File: rtl/plane_busy_set.sv
module plane_busy_set #(
  parameter int NUM_PLANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  track_en,
  input  logic [NUM_PLANES-1:0] inv_bits,
  input  logic [NUM_PLANES-1:0] fl_bits,
  input  logic                  force_exit,
  output logic [NUM_PLANES-1:0] busy_q,
  output logic [NUM_PLANES-1:0] busy_nx,
  output logic                  exit_req
);

  logic                  en_q;
  logic [NUM_PLANES-1:0] base;
  logic                  busy_ld;

  always_comb begin
    // a fresh enable starts from a clean set
    base    = en_q ? busy_q : '0;
    busy_ld = track_en;
    busy_nx = busy_ld ? ((base & ~fl_bits) | inv_bits) : busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      exit_req <= 1'b0;
    end else begin
      en_q     <= track_en;
      exit_req <= force_exit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (busy_ld) begin
      busy_q <= busy_nx;
    end
  end

  AST_INV_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_bits != '0) |=> (exit_req && ((busy_q & $past(inv_bits)) == $past(inv_bits)))); // R2

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && inv_bits == '0) |=> ((busy_q & $past(fl_bits)) == '0)); // R3

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> $stable(busy_q)); // R9

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (track_en && !en_q && inv_bits == '0) |=> (busy_q == '0)); // R10

endmodule

// File: rtl/rearm_sequencer.sv
module rearm_sequencer
  import plane_trk_pkg::*;
#(
  parameter int NUM_PLANES       = 8,
  parameter int HW_DELAY_CYC     = 100,
  parameter int SW_DELAY_CYC     = 500,
  parameter int IDLE_TIMEOUT_CYC = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  track_en,
  input  logic                  hw_mode,
  input  logic                  flush_seen,
  input  logic                  inv_hit,
  input  logic                  force_exit,
  input  logic [NUM_PLANES-1:0] busy_nx,
  input  logic [NUM_PLANES-1:0] busy_q,
  input  logic                  sr_active,
  input  logic                  ctrl_idle,
  output logic                  rearm_req,
  output logic                  rearm_err
);

  localparam int MAX_DLY = (HW_DELAY_CYC > SW_DELAY_CYC) ? HW_DELAY_CYC : SW_DELAY_CYC;
  localparam int MAX_CNT = (MAX_DLY > IDLE_TIMEOUT_CYC) ? MAX_DLY : IDLE_TIMEOUT_CYC;
  localparam int CW      = $clog2(MAX_CNT + 1);
  localparam logic [CW-1:0] HW_LD = CW'(HW_DELAY_CYC - 1);
  localparam logic [CW-1:0] SW_LD = CW'(SW_DELAY_CYC - 1);
  localparam logic [CW-1:0] TO_LD = CW'(IDLE_TIMEOUT_CYC - 1);

  rearm_st_e     st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_ld;
  logic          rearm_nx, err_nx;
  logic          start_ok;
  logic          cancel;

  always_comb begin
    start_ok = flush_seen && (busy_nx == '0) && (!sr_active || force_exit);
    cancel   = !track_en || inv_hit;
    st_nx    = st_q;
    cnt_nx   = cnt_q;
    cnt_ld   = 1'b0;
    rearm_nx = 1'b0;
    err_nx   = 1'b0;
    unique case (st_q)
      RA_IDLE: begin
        if (start_ok) begin
          st_nx  = RA_DELAY;
          cnt_nx = hw_mode ? HW_LD : SW_LD;
          cnt_ld = 1'b1;
        end
      end
      RA_DELAY: begin
        if (cancel) begin
          st_nx = RA_IDLE;
        end else if (cnt_q == '0) begin
          st_nx  = RA_WAIT;
          cnt_nx = TO_LD;
          cnt_ld = 1'b1;
        end else begin
          cnt_nx = cnt_q - 1'b1;
          cnt_ld = 1'b1;
        end
      end
      RA_WAIT: begin
        if (cancel || (busy_q != '0)) begin
          st_nx = RA_IDLE;
        end else if (ctrl_idle) begin
          st_nx    = RA_IDLE;
          rearm_nx = 1'b1;
        end else if (cnt_q == '0) begin
          st_nx  = RA_IDLE;
          err_nx = 1'b1;
        end else begin
          cnt_nx = cnt_q - 1'b1;
          cnt_ld = 1'b1;
        end
      end
      default: st_nx = RA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RA_IDLE;
      rearm_req <= 1'b0;
      rearm_err <= 1'b0;
    end else begin
      st_q      <= st_nx;
      rearm_req <= rearm_nx;
      rearm_err <= err_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_nx;
    end
  end

  AST_REARM_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_req |-> $past(ctrl_idle)); // R6

  AST_INV_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_hit |=> !rearm_req); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rearm_req, rearm_err})); // R8

  AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> (!rearm_req && !rearm_err)); // R9

endmodule

// File: rtl/plane_dirty_rearm.sv
module plane_dirty_rearm #(
  parameter int NUM_PLANES       = 8,
  parameter int HW_DELAY_CYC     = 100,
  parameter int SW_DELAY_CYC     = 500,
  parameter int IDLE_TIMEOUT_CYC = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  track_en,
  input  logic                  hw_mode,
  input  logic [NUM_PLANES-1:0] pipe_mask,
  input  logic                  inv_valid,
  input  logic [NUM_PLANES-1:0] inv_mask,
  input  logic                  flush_valid,
  input  logic [NUM_PLANES-1:0] flush_mask,
  input  logic                  flush_is_flip,
  input  logic                  sr_active,
  input  logic                  ctrl_idle,
  output logic [NUM_PLANES-1:0] busy,
  output logic                  exit_req,
  output logic                  rearm_req,
  output logic                  rearm_err
);

  logic [NUM_PLANES-1:0] inv_bits;
  logic [NUM_PLANES-1:0] fl_bits;
  logic [NUM_PLANES-1:0] busy_nx;
  logic                  inv_hit;
  logic                  flush_seen;
  logic                  force_exit;

  plane_evt_filter #(.NUM_PLANES(NUM_PLANES)) i_filter (
    .track_en      (track_en),
    .hw_mode       (hw_mode),
    .pipe_mask     (pipe_mask),
    .inv_valid     (inv_valid),
    .inv_mask      (inv_mask),
    .flush_valid   (flush_valid),
    .flush_mask    (flush_mask),
    .flush_is_flip (flush_is_flip),
    .inv_bits      (inv_bits),
    .fl_bits       (fl_bits),
    .inv_hit       (inv_hit),
    .flush_seen    (flush_seen),
    .force_exit    (force_exit)
  );

  plane_busy_set #(.NUM_PLANES(NUM_PLANES)) i_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .track_en   (track_en),
    .inv_bits   (inv_bits),
    .fl_bits    (fl_bits),
    .force_exit (force_exit),
    .busy_q     (busy),
    .busy_nx    (busy_nx),
    .exit_req   (exit_req)
  );

  rearm_sequencer #(
    .NUM_PLANES       (NUM_PLANES),
    .HW_DELAY_CYC     (HW_DELAY_CYC),
    .SW_DELAY_CYC     (SW_DELAY_CYC),
    .IDLE_TIMEOUT_CYC (IDLE_TIMEOUT_CYC)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .track_en   (track_en),
    .hw_mode    (hw_mode),
    .flush_seen (flush_seen),
    .inv_hit    (inv_hit),
    .force_exit (force_exit),
    .busy_nx    (busy_nx),
    .busy_q     (busy),
    .sr_active  (sr_active),
    .ctrl_idle  (ctrl_idle),
    .rearm_req  (rearm_req),
    .rearm_err  (rearm_err)
  );

endmodule

// File: tb/test_plane_dirty_rearm.sv
module test_plane_dirty_rearm;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int HW  = 40;
  localparam int SW  = 90;
  localparam int TO  = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          track_en, hw_mode, inv_valid, flush_valid, flush_is_flip;
  logic          sr_active, ctrl_idle;
  logic [NP-1:0] pipe_mask, inv_mask, flush_mask, busy;
  logic          exit_req, rearm_req, rearm_err;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int exit_q[$];
  int rearm_q[$];
  int err_q[$];
  logic [NP-1:0] mdl_busy = '0;
  bit pending = 0;
  bit pend_is_err = 0;
  int pend_end = 0;

  plane_dirty_rearm #(
    .NUM_PLANES(NP), .HW_DELAY_CYC(HW), .SW_DELAY_CYC(SW), .IDLE_TIMEOUT_CYC(TO)
  ) i_plane_dirty_rearm (
    .clk(clk), .rst_n(rst_n), .track_en(track_en), .hw_mode(hw_mode),
    .pipe_mask(pipe_mask), .inv_valid(inv_valid), .inv_mask(inv_mask),
    .flush_valid(flush_valid), .flush_mask(flush_mask), .flush_is_flip(flush_is_flip),
    .sr_active(sr_active), .ctrl_idle(ctrl_idle), .busy(busy),
    .exit_req(exit_req), .rearm_req(rearm_req), .rearm_err(rearm_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic cmp_pulse(input string tag, ref int q[$]);
    compared++;
    if (q.size() == 0) begin
      mismatched++;
      $display("FAIL %s: pulse at cycle %0d, expected none", tag, cyc);
    end else begin
      if (q[0] != cyc) begin
        mismatched++;
        $display("FAIL %s: pulse at cycle %0d, expected cycle %0d", tag, cyc, q[0]);
      end
      void'(q.pop_front());
    end
  endtask

  // monitor and controller model: pops expected pulses, tracks self-refresh state
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (exit_req)  cmp_pulse("R2/R4/R5 exit_req", exit_q);
        if (rearm_req) cmp_pulse("R6/R7 rearm_req", rearm_q);
        if (rearm_err) cmp_pulse("R8 rearm_err", err_q);
        if (rearm_req)     sr_active = 1'b1;
        else if (exit_req) sr_active = 1'b0;
      end
    end
  end

  task automatic chk_busy(input string tag);
    compared++;
    if (busy !== mdl_busy) begin
      mismatched++;
      $display("FAIL %s: busy=%h expected %h", tag, busy, mdl_busy);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  // driver: predicts the result of one event and pushes expected pulses
  task automatic ev(input bit iv, input logic [NP-1:0] im_raw,
                    input bit fv, input logic [NP-1:0] fm_raw, input bit flip);
    int c;
    int dly;
    logic [NP-1:0] im, fm;
    bit frc;
    c = cyc;
    if (pending && c >= pend_end) pending = 0;
    if (track_en) begin
      im = iv ? (im_raw & pipe_mask) : '0;
      fm = fv ? (fm_raw & pipe_mask) : '0;
      mdl_busy = (mdl_busy & ~fm) | im;
      frc = (im != 0) || ((fm != 0) && (!hw_mode || !flip));
      if (frc) exit_q.push_back(c + 1);
      if ((im != 0) && pending) begin
        if (pend_is_err) void'(err_q.pop_back());
        else void'(rearm_q.pop_back());
        pending = 0;
      end
      if (fv && (mdl_busy == 0) && (!sr_active || frc) && !pending) begin
        dly = hw_mode ? HW : SW;
        pending = 1;
        if (ctrl_idle) begin
          pend_is_err = 0;
          pend_end = c + dly + 2;
          rearm_q.push_back(pend_end);
        end else begin
          pend_is_err = 1;
          pend_end = c + 1 + dly + TO;
          err_q.push_back(pend_end);
        end
      end
    end
    inv_valid = iv; inv_mask = im_raw;
    flush_valid = fv; flush_mask = fm_raw; flush_is_flip = flip;
    @(negedge clk); #1;
    inv_valid = 0; flush_valid = 0; inv_mask = '0; flush_mask = '0; flush_is_flip = 0;
  endtask

  task automatic set_en(input bit en);
    if (pending && cyc >= pend_end) pending = 0;
    if (!en && pending) begin
      if (pend_is_err) void'(err_q.pop_back());
      else void'(rearm_q.pop_back());
      pending = 0;
    end
    if (en) mdl_busy = '0;
    track_en = en;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end

  initial begin
    rst_n = 0; track_en = 0; hw_mode = 1; pipe_mask = 8'h0F;
    inv_valid = 0; inv_mask = '0; flush_valid = 0; flush_mask = '0; flush_is_flip = 0;
    sr_active = 0; ctrl_idle = 1;
    step(3);
    rst_n = 1;
    step(2);
    chk_busy("R10 reset state");

    set_en(1);
    chk_busy("R10 first enable");

    ev(1, 8'hF3, 0, '0, 0);            // R1 R2: masked to 0x03
    chk_busy("R1/R2 invalidate");
    ev(1, 8'hF0, 0, '0, 0);            // R1: outside pipe, no exit
    chk_busy("R1 outside mask ignored");
    ev(0, '0, 1, 8'h01, 1);            // R4: flip flush, silent
    chk_busy("R3/R4 flip flush clears");
    ev(0, '0, 1, 8'h02, 0);            // R4: non-flip exits; R6 timer hw
    chk_busy("R3 flush clears last bit");
    step(HW + 5);

    ev(1, 8'h04, 1, 8'h04, 0);         // R11 both in one cycle
    chk_busy("R11 invalidate wins");

    hw_mode = 0;
    ev(0, '0, 1, 8'h04, 1);            // R5: sw flip still exits; R6 sw delay
    chk_busy("R5 sw flush clears");
    step(SW + 5);

    hw_mode = 1;
    ev(1, 8'h08, 0, '0, 0);
    step(1);
    ev(0, '0, 1, 8'h08, 1);            // timer starts with sr inactive
    step(10);
    ev(1, 8'h01, 0, '0, 0);            // R7 cancel
    chk_busy("R7 cancel invalidate");
    step(HW + 10);
    ev(0, '0, 1, 8'h01, 0);            // R6 new rearm
    step(HW + 5);

    ev(1, 8'h02, 0, '0, 0);
    step(1);
    ctrl_idle = 0;
    ev(0, '0, 1, 8'h02, 1);            // R8 timeout
    step(HW + TO + 5);
    ctrl_idle = 1;

    ev(1, 8'h04, 0, '0, 0);
    step(1);
    ev(0, '0, 1, 8'h04, 1);            // timer pending
    step(5);
    set_en(0);                         // R9 cancel by disable
    ev(1, 8'h01, 0, '0, 0);            // R9 ignored while off
    chk_busy("R9 invalidate ignored");
    step(HW + 10);
    set_en(1);
    chk_busy("R10 re-enable clean");
    ev(1, 8'h02, 0, '0, 0);
    chk_busy("R2 invalidate after enable");
    set_en(0);
    ev(0, '0, 1, 8'h02, 0);            // R9 flush ignored
    chk_busy("R9 flush ignored, busy held");
    set_en(1);
    chk_busy("R10 enable clears busy");
    step(10);

    while (exit_q.size() > 0) begin
      mismatched++; compared++;
      $display("FAIL R2 exit_req: missing, expected cycle %0d", exit_q.pop_front());
    end
    while (rearm_q.size() > 0) begin
      mismatched++; compared++;
      $display("FAIL R6 rearm_req: missing, expected cycle %0d", rearm_q.pop_front());
    end
    while (err_q.size() > 0) begin
      mismatched++; compared++;
      $display("FAIL R8 rearm_err: missing, expected cycle %0d", err_q.pop_front());
    end
    report();
  end

endmodule